// File: doc/BRIEF.md
# Cycle-Programmable Memory Strobe Generator

This block times a single access on an external memory bus. A fast functional clock drives everything. When an access is launched, a cycle counter starts at zero and advances once per functional-clock cycle until it passes a programmed cycle limit. Chip select, output enable and write enable are driven active-low. Each of them asserts on the cycle whose count equals its programmed start value and releases on the cycle whose count equals its programmed stop value. Any of them can be pushed back by half a functional-clock period.

The block also drives an external bus clock. This clock runs at the functional rate divided by one to four, stays low until a programmable activation cycle, and stops at the end of the access. All strobes are launched from functional-clock edges, whatever the divider is set to. As a result, each strobe edge falls at a fixed sub-phase of the bus-clock period. For every strobe transition the block reports that sub-phase in half-cycles, so that the board timing of each edge can be worked out against the bus clock.

The timing settings are captured when an access is launched and stay fixed until it ends. Address and data steering, wait handling and bursts belong to other blocks.

Top module: `pstrb_gen`

## Requirements
- R1: After reset, and whenever no access is running, `cs_n`, `oe_n`, `we_n` and `busy_n` are high, `bus_clk` is low and `edge_vld` is low.
- R2: A high `start` seen at a rising `clk` edge while idle launches an access. That edge is count 0, and `busy_n` stays low from count 0 through count `cyc_lim`, for `cyc_lim`+1 cycles. A `start` seen during an access is ignored.
- R3: All timing inputs are sampled at the launching edge. Changing them during an access has no effect on that access.
- R4: A strobe goes active at the edge where the count equals its on value and inactive at the edge where the count equals its off value. If on equals off, the strobe never goes active. If off is below on, the strobe stays active from on until the access ends. If on exceeds `cyc_lim`, the strobe never goes active.
- R5: `dly_sel` bit 0 (chip select), bit 1 (output enable) and bit 2 (write enable) each delay both edges of their strobe by half a `clk` period.
- R6: At the edge after count `cyc_lim` (count `cyc_lim`+1), all strobes are released, subject only to their half-cycle delay, `bus_clk` goes low and `busy_n` rises.
- R7: `bus_clk` has a period of D = `div_sel`+1 functional cycles. Its rising edge lines up with a `clk` rising edge, and it is high for the first D half-periods of `clk` in each of its periods.
- R8: The first rising edge of `bus_clk` comes at count `clk_act`. If `clk_act` is greater than `cyc_lim`, the bus clock stays low for the whole access.
- R9: For a strobe transition launched at count t, `edge_vld` is high during the `clk` cycle that follows that edge. `edge_lane` gives 0 for chip select, 1 for output enable and 2 for write enable, and picks the lowest of these when several change at the same edge.
- R10: `edge_phase` equals 2·((t − `clk_act`) mod D) plus the lane's delay bit, where the mod result is taken in the range 0..D−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted when idle |
| cs_on | input | CNT_W | Chip-select assert count |
| cs_off | input | CNT_W | Chip-select release count |
| oe_on | input | CNT_W | Output-enable assert count |
| oe_off | input | CNT_W | Output-enable release count |
| we_on | input | CNT_W | Write-enable assert count |
| we_off | input | CNT_W | Write-enable release count |
| dly_sel | input | 3 | Half-cycle delay per strobe (bit 0 cs, 1 oe, 2 we) |
| div_sel | input | 2 | Bus clock ratio minus one |
| clk_act | input | CNT_W | Count of first bus-clock rising edge |
| cyc_lim | input | CNT_W | Last count of the access |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| bus_clk | output | 1 | External bus clock |
| busy_n | output | 1 | Access in progress, active low |
| edge_vld | output | 1 | A strobe transition happened at the last edge |
| edge_lane | output | 2 | Strobe that changed |
| edge_phase | output | 3 | Edge offset from bus-clock rise, in half-cycles |

## Verification
A wrong count or a wrong latched setting moves a strobe edge by a whole cycle. The misplaced edge appears at the pins in the first half-cycle sample after the edge that should have launched it. A fault in the half-cycle path appears as a strobe level that is wrong only in the first half of a cycle, so both halves of every cycle are sampled. A wrong divider phase shows up in `bus_clk` within one bus-clock period of activation, and in `edge_phase` in the cycle after the next strobe edge. A launch that was not ignored shows up as `busy_n` staying low past count `cyc_lim`+1.

// File: rtl/pstrb_pkg.sv
package pstrb_pkg;

  localparam int unsigned LANES  = 3;
  localparam int unsigned TIME_W = 16;

  // Non-negative remainder of a signed cycle distance by the bus clock ratio.
  function automatic logic [1:0] sub_phase(input logic signed [TIME_W-1:0] diff,
                                           input logic [2:0] ratio);
    logic signed [TIME_W-1:0] den;
    logic signed [TIME_W-1:0] rem;
    den = $signed({{(TIME_W-3){1'b0}}, ratio});
    rem = diff % den;
    if (rem < 0) rem = rem + den;
    return rem[1:0];
  endfunction

  // Bus clock level for a phase slot and a half of the functional period:
  // high while the half-period index 2*ph+half is below the ratio.
  function automatic logic clk_level(input logic [1:0] ph, input logic half,
                                     input logic [2:0] ratio);
    return ({ph, half} < ratio);
  endfunction

  // Offset in half-cycles: whole-cycle slot doubled plus the delay bit.
  function automatic logic [2:0] half_offset(input logic [1:0] k, input logic xd);
    return {k, xd};
  endfunction

  // Lowest-numbered changed lane.
  function automatic logic [1:0] first_lane(input logic [LANES-1:0] chg);
    if (chg[0]) return 2'd0;
    if (chg[1]) return 2'd1;
    return 2'd2;
  endfunction

endpackage

// File: rtl/pstrb_access_ctr.sv
module pstrb_access_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cyc_lim,
  output logic             active_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active_nxt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             launch,
  output logic             fin,
  output logic [CNT_W:0]   t_nxt
);

  assign launch     = start && !active_q;
  assign fin        = active_q && (cnt_q == cyc_lim);
  assign active_nxt = launch || (active_q && !fin);
  assign cnt_nxt    = (active_q && !fin) ? cnt_q + 1'b1 : '0;
  // Count index of the edge about to happen (end edge is cyc_lim+1).
  assign t_nxt      = active_q ? ({1'b0, cnt_q} + 1'b1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_nxt;
      cnt_q    <= cnt_nxt;
    end
  end

endmodule

// File: rtl/pstrb_lane.sv
module pstrb_lane #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_nxt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] on_t,
  input  logic [CNT_W-1:0] off_t,
  input  logic             xdly,
  output logic             rise_nxt,
  output logic             rise_q,
  output logic             strobe_n
);

  logic fall_q;

  always_comb begin
    if (!act_nxt)               rise_nxt = 1'b0;
    else if (cnt_nxt == off_t)  rise_nxt = 1'b0;
    else if (cnt_nxt == on_t)   rise_nxt = 1'b1;
    else                        rise_nxt = rise_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= rise_nxt;
  end

  // Half-period copy; select is a register that only changes while both are idle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign strobe_n = ~(xdly ? fall_q : rise_q);

endmodule

// File: rtl/pstrb_busclk.sv
module pstrb_busclk #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_nxt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] act_t,
  input  logic [2:0]       ratio_p,
  input  logic [2:0]       ratio_n,
  output logic             bus_clk
);
  import pstrb_pkg::*;

  logic       run_q, run_nxt;
  logic [1:0] ph_q, ph_nxt;
  logic       hi_p, hi_n;
  logic       q_p, q_n;

  assign run_nxt = act_nxt && (cnt_nxt >= act_t);

  always_comb begin
    if (!run_nxt || !run_q)                 ph_nxt = 2'd0;
    else if ({1'b0, ph_q} == ratio_p - 3'd1) ph_nxt = 2'd0;
    else                                    ph_nxt = ph_q + 2'd1;
  end

  assign hi_p = run_nxt && clk_level(ph_nxt, 1'b0, ratio_p);
  assign hi_n = run_q   && clk_level(ph_q,   1'b1, ratio_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= 2'd0;
      q_p   <= 1'b0;
    end else begin
      run_q <= run_nxt;
      ph_q  <= ph_nxt;
      q_p   <= hi_p ^ q_n;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_n <= 1'b0;
    else        q_n <= hi_n ^ q_p;
  end

  // Each flop toggles only when its half wants a new level.
  assign bus_clk = q_p ^ q_n;

endmodule

// File: rtl/pstrb_phase_track.sv
module pstrb_phase_track #(
  parameter int CNT_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [pstrb_pkg::LANES-1:0]    rise_nxt,
  input  logic [pstrb_pkg::LANES-1:0]    rise_q,
  input  logic [CNT_W:0]                 t_nxt,
  input  logic [CNT_W-1:0]               act_t,
  input  logic [2:0]                     ratio,
  input  logic [pstrb_pkg::LANES-1:0]    xdly,
  output logic                           edge_vld,
  output logic [1:0]                     edge_lane,
  output logic [2:0]                     edge_phase
);
  import pstrb_pkg::*;

  logic [LANES-1:0]         chg;
  logic [1:0]               lane;
  logic                     xd_sel;
  logic signed [TIME_W-1:0] diff;
  logic [1:0]               k;

  assign chg  = rise_nxt ^ rise_q;
  assign lane = first_lane(chg);
  assign diff = $signed({{(TIME_W-CNT_W-1){1'b0}}, t_nxt})
              - $signed({{(TIME_W-CNT_W){1'b0}}, act_t});
  assign k    = sub_phase(diff, ratio);

  always_comb begin
    case (lane)
      2'd0:    xd_sel = xdly[0];
      2'd1:    xd_sel = xdly[1];
      default: xd_sel = xdly[2];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_vld   <= 1'b0;
      edge_lane  <= 2'd0;
      edge_phase <= 3'd0;
    end else begin
      edge_vld   <= |chg;
      edge_lane  <= lane;
      edge_phase <= half_offset(k, xd_sel);
    end
  end

endmodule

// File: rtl/pstrb_gen.sv
module pstrb_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cs_on,
  input  logic [CNT_W-1:0] cs_off,
  input  logic [CNT_W-1:0] oe_on,
  input  logic [CNT_W-1:0] oe_off,
  input  logic [CNT_W-1:0] we_on,
  input  logic [CNT_W-1:0] we_off,
  input  logic [2:0]       dly_sel,
  input  logic [1:0]       div_sel,
  input  logic [CNT_W-1:0] clk_act,
  input  logic [CNT_W-1:0] cyc_lim,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             bus_clk,
  output logic             busy_n,
  output logic             edge_vld,
  output logic [1:0]       edge_lane,
  output logic [2:0]       edge_phase
);
  import pstrb_pkg::*;

  // Captured settings
  logic [LANES-1:0][CNT_W-1:0] on_in, off_in, on_q, off_q, on_eff, off_eff;
  logic [LANES-1:0]            dly_q, dly_eff;
  logic [1:0]                  div_q, div_eff;
  logic [CNT_W-1:0]            clkact_q, clkact_eff, lim_q;
  logic [2:0]                  ratio_eff, ratio_q;

  // Named internal events
  logic             acc_active, acc_active_nxt, acc_launch, acc_fin;
  logic [CNT_W-1:0] acc_cnt, acc_cnt_nxt;
  logic [CNT_W:0]   acc_t_nxt;
  logic [LANES-1:0] lane_rise_nxt, lane_rise_q, lane_n;

  assign on_in  = {we_on,  oe_on,  cs_on};
  assign off_in = {we_off, oe_off, cs_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q     <= '0;
      off_q    <= '0;
      dly_q    <= '0;
      div_q    <= '0;
      clkact_q <= '0;
      lim_q    <= '0;
    end else if (acc_launch) begin
      on_q     <= on_in;
      off_q    <= off_in;
      dly_q    <= dly_sel;
      div_q    <= div_sel;
      clkact_q <= clk_act;
      lim_q    <= cyc_lim;
    end
  end

  // On the launching edge the live inputs apply; afterwards the snapshot.
  assign on_eff     = acc_launch ? on_in   : on_q;
  assign off_eff    = acc_launch ? off_in  : off_q;
  assign dly_eff    = acc_launch ? dly_sel : dly_q;
  assign div_eff    = acc_launch ? div_sel : div_q;
  assign clkact_eff = acc_launch ? clk_act : clkact_q;
  assign ratio_eff  = {1'b0, div_eff} + 3'd1;
  assign ratio_q    = {1'b0, div_q} + 3'd1;

  pstrb_access_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cyc_lim    (lim_q),
    .active_q   (acc_active),
    .cnt_q      (acc_cnt),
    .active_nxt (acc_active_nxt),
    .cnt_nxt    (acc_cnt_nxt),
    .launch     (acc_launch),
    .fin        (acc_fin),
    .t_nxt      (acc_t_nxt)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pstrb_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_nxt  (acc_active_nxt),
      .cnt_nxt  (acc_cnt_nxt),
      .on_t     (on_eff[i]),
      .off_t    (off_eff[i]),
      .xdly     (dly_q[i]),
      .rise_nxt (lane_rise_nxt[i]),
      .rise_q   (lane_rise_q[i]),
      .strobe_n (lane_n[i])
    );
  end

  pstrb_busclk #(.CNT_W(CNT_W)) u_bclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_nxt (acc_active_nxt),
    .cnt_nxt (acc_cnt_nxt),
    .act_t   (clkact_eff),
    .ratio_p (ratio_eff),
    .ratio_n (ratio_q),
    .bus_clk (bus_clk)
  );

  pstrb_phase_track #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_nxt   (lane_rise_nxt),
    .rise_q     (lane_rise_q),
    .t_nxt      (acc_t_nxt),
    .act_t      (clkact_eff),
    .ratio      (ratio_eff),
    .xdly       (dly_eff),
    .edge_vld   (edge_vld),
    .edge_lane  (edge_lane),
    .edge_phase (edge_phase)
  );

  assign cs_n   = lane_n[0];
  assign oe_n   = lane_n[1];
  assign we_n   = lane_n[2];
  assign busy_n = ~acc_active;

endmodule

// File: rtl/pstrb_checker.sv
module pstrb_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_n,
  input logic             cs_n,
  input logic             oe_n,
  input logic             we_n,
  input logic             bus_clk,
  input logic             edge_vld,
  input logic [1:0]       edge_lane,
  input logic [2:0]       edge_phase,
  input logic             acc_active,
  input logic [CNT_W-1:0] acc_cnt,
  input logic [CNT_W-1:0] lim_q,
  input logic [1:0]       div_q
);

  logic [3:0] phase_lim;
  assign phase_lim = ({2'b00, div_q} + 4'd1) << 1;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && $past(busy_n)) |-> (cs_n && oe_n && we_n && !edge_vld));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_active && acc_cnt != lim_q) |=> (acc_active && acc_cnt == $past(acc_cnt) + 1'b1));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_active |-> (acc_cnt <= lim_q));

  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_active && acc_cnt == lim_q) |=> busy_n);

  assert_bus_low_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && $past(busy_n)) |-> !bus_clk);

  assert_lane_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_vld |-> (edge_lane != 2'd3));

  assert_phase_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_vld |-> ({1'b0, edge_phase} < phase_lim));

endmodule

bind pstrb_gen pstrb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_n     (busy_n),
  .cs_n       (cs_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .bus_clk    (bus_clk),
  .edge_vld   (edge_vld),
  .edge_lane  (edge_lane),
  .edge_phase (edge_phase),
  .acc_active (acc_active),
  .acc_cnt    (acc_cnt),
  .lim_q      (lim_q),
  .div_q      (div_q)
);

// File: tb/pstrb_gen_bench.sv
module pstrb_gen_bench;

  localparam int CNT_W = 5;
  localparam int P     = 8;
  localparam int QTR   = 2;

  logic             clk, rst_n, start;
  logic [CNT_W-1:0] cs_on, cs_off, oe_on, oe_off, we_on, we_off, clk_act, cyc_lim;
  logic [2:0]       dly_sel;
  logic [1:0]       div_sel;
  logic             cs_n, oe_n, we_n, bus_clk, busy_n, edge_vld;
  logic [1:0]       edge_lane;
  logic [2:0]       edge_phase;

  pstrb_gen #(.CNT_W(CNT_W)) u_pstrb_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cs_on(cs_on), .cs_off(cs_off), .oe_on(oe_on), .oe_off(oe_off),
    .we_on(we_on), .we_off(we_off), .dly_sel(dly_sel), .div_sel(div_sel),
    .clk_act(clk_act), .cyc_lim(cyc_lim),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .bus_clk(bus_clk), .busy_n(busy_n),
    .edge_vld(edge_vld), .edge_lane(edge_lane), .edge_phase(edge_phase)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Model settings for the running access
  int c_on[3], c_off[3], c_x[3];
  int c_div, c_act, c_cyc;

  initial clk = 1'b0;
  always #(P/2) clk = ~clk;

  function automatic int pmod(int a, int d);
    int r;
    r = a % d;
    if (r < 0) r += d;
    return r;
  endfunction

  // Rise-domain state of a lane at count t (R4, R6)
  function automatic bit raw_on(int l, int t);
    if (t < c_on[l] || t > c_cyc) return 0;
    if (c_off[l] >= c_on[l] && c_off[l] <= t) return 0;
    return 1;
  endfunction

  // Pin level (active-high) in half h of cycle t (R5)
  function automatic bit pin_on(int l, int t, int h);
    if (c_x[l] != 0 && h == 0) return raw_on(l, t - 1);
    return raw_on(l, t);
  endfunction

  // Bus clock level (R7, R8)
  function automatic bit bus_exp(int t, int h);
    int d;
    d = c_div + 1;
    if (t < c_act || t > c_cyc) return 0;
    return (2 * pmod(t - c_act, d) + h) < d;
  endfunction

  task automatic chk(string req, string what, int t, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s t=%0d got %0d expected %0d", req, what, t, got, exp);
    end
  endtask

  task automatic check_half(int t, int h);
    chk("R4/R5", "cs level", t, int'(!cs_n), int'(pin_on(0, t, h)));
    chk("R4/R5", "oe level", t, int'(!oe_n), int'(pin_on(1, t, h)));
    chk("R4/R5", "we level", t, int'(!we_n), int'(pin_on(2, t, h)));
    chk("R7/R8", "bus_clk",  t, int'(bus_clk), int'(bus_exp(t, h)));
    if (h == 0) begin
      int lane, ev;
      chk("R2/R6", "busy", t, int'(!busy_n), int'(t <= c_cyc));
      lane = -1;
      for (int l = 2; l >= 0; l--)
        if (raw_on(l, t) != raw_on(l, t - 1)) lane = l;
      ev = (lane >= 0);
      chk("R9", "edge_vld", t, int'(edge_vld), ev);
      if (ev != 0 && edge_vld) begin
        chk("R9", "edge_lane", t, int'(edge_lane), lane);
        chk("R10", "edge_phase", t, int'(edge_phase),
            2 * pmod(t - c_act, c_div + 1) + c_x[lane]);
      end
    end
  endtask

  task automatic set_cfg(int con, int coff, int oon, int ooff, int won, int woff,
                         int x, int dv, int act, int cyc);
    c_on[0] = con; c_off[0] = coff;
    c_on[1] = oon; c_off[1] = ooff;
    c_on[2] = won; c_off[2] = woff;
    c_x[0] = x & 1; c_x[1] = (x >> 1) & 1; c_x[2] = (x >> 2) & 1;
    c_div = dv; c_act = act; c_cyc = cyc;
  endtask

  task automatic run_access();
    @(negedge clk);
    cs_on = CNT_W'(c_on[0]); cs_off = CNT_W'(c_off[0]);
    oe_on = CNT_W'(c_on[1]); oe_off = CNT_W'(c_off[1]);
    we_on = CNT_W'(c_on[2]); we_off = CNT_W'(c_off[2]);
    dly_sel = {c_x[2][0], c_x[1][0], c_x[0][0]};
    div_sel = 2'(c_div); clk_act = CNT_W'(c_act); cyc_lim = CNT_W'(c_cyc);
    start = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= c_cyc + 2; t++) begin
      #(QTR);
      check_half(t, 0);
      @(negedge clk);
      if (t == 0) begin
        // R3: settings scrambled mid-access; start kept high across edge 1 (R2)
        cs_on = CNT_W'($urandom); cs_off = CNT_W'($urandom);
        oe_on = CNT_W'($urandom); oe_off = CNT_W'($urandom);
        we_on = CNT_W'($urandom); we_off = CNT_W'($urandom);
        dly_sel = 3'($urandom); div_sel = 2'($urandom);
        clk_act = CNT_W'($urandom); cyc_lim = CNT_W'($urandom);
      end
      if (t == 1) start = 1'b0;
      #(QTR);
      check_half(t, 1);
      @(posedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0;
    cs_on = '0; cs_off = '0; oe_on = '0; oe_off = '0; we_on = '0; we_off = '0;
    dly_sel = '0; div_sel = '0; clk_act = '0; cyc_lim = '0;
    @(posedge clk); #(QTR);
    // R1: reset state
    chk("R1", "reset cs_n", 0, int'(cs_n), 1);
    chk("R1", "reset oe_n", 0, int'(oe_n), 1);
    chk("R1", "reset we_n", 0, int'(we_n), 1);
    chk("R1", "reset busy_n", 0, int'(busy_n), 1);
    chk("R1", "reset bus_clk", 0, int'(bus_clk), 0);
    chk("R1", "reset edge_vld", 0, int'(edge_vld), 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Divide-by-4 with offset activation, mixed delays
    set_cfg(0, 12, 3, 7, 5, 10, 3'b010, 3, 1, 13);  run_access();
    set_cfg(1, 14, 2, 9, 6, 11, 3'b100, 3, 2, 15);  run_access();
    // Divide-by-1, all strobes delayed, activation at 0
    set_cfg(0, 4, 1, 3, 2, 5, 3'b111, 0, 0, 6);     run_access();
    // Divide-by-3: on==off, off<on, on beyond the limit
    set_cfg(20, 25, 4, 4, 6, 2, 3'b001, 2, 4, 10);  run_access();
    // Activation beyond the limit: bus clock silent (R8)
    set_cfg(1, 3, 2, 4, 0, 1, 3'b000, 1, 9, 5);     run_access();
    // Shortest access
    set_cfg(0, 0, 0, 1, 0, 3, 3'b110, 1, 0, 0);     run_access();
    // Divide-by-2, activation late, edges before activation
    set_cfg(0, 8, 1, 5, 2, 7, 3'b000, 1, 3, 9);     run_access();

    for (int n = 0; n < 40; n++) begin
      set_cfg(int'($urandom % 24), int'($urandom % 24), int'($urandom % 24),
              int'($urandom % 24), int'($urandom % 24), int'($urandom % 24),
              int'($urandom % 8), int'($urandom % 4), int'($urandom % 24),
              int'($urandom % 21));
      run_access();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule